// File: doc/BRIEF.md
# Supply Monitor with Clock-Blanking Control

This block turns the raw digital outputs of five supply comparators into interrupts, a reset request and a clock freeze. Two of the comparators watch the pad supply: one for a pre-warning level and one for a brownout level. Three watch the core supply: one for an upper clip level, one for a drop level and one for a brownout level. Each comparator output is first synchronized to the reference clock. It then passes through a glitch filter before any action is taken.

A rising pre-warning, clip or drop condition produces a one-cycle interrupt pulse. A drop also starts clock blanking. The enables for the main clock and for the peripheral clock both go low together for a programmable number of reference cycles. The enables change only on the falling reference edge, so that a downstream AND gate produces no runt pulse. After a drop, a status output stays low until the freeze has finished and the drop condition has cleared.

Any brownout condition asserts the reset request. The request is released only after every brownout condition has stayed clear for a fixed hold period. The same path produces the power-on reset after the block's own reset is released.

Top module: `supply_guard`

## Requirements
- R1: Each comparator input is synchronized through two flops and acts only once its synchronized value has differed from the filtered value for 4 consecutive reference cycles. A raw pulse of 2 cycles causes no interrupt and no reset.
- R2: When the filtered pad pre-warning condition rises, `pad_warn_irq` is high for exactly one cycle. It does not pulse again while the condition stays high.
- R3: When the filtered core clip condition rises, `core_clip_irq` is high for exactly one cycle.
- R4: When the filtered core drop condition rises, `core_drop_irq` is high for exactly one cycle, and blanking starts in the same cycle if the blanking FSM is in RUN.
- R5: During blanking, `mclk_en` and `pclk_en` are low for exactly `blank_len` reference cycles. A `blank_len` of 0 selects the default of 8. The two enables are equal at all times.
- R6: `core_ok` is low from the start of blanking until the freeze has ended and the filtered drop condition is low. It is also low while the filtered core brownout condition is high. After recovery, `core_ok` returns to 1.
- R7: A filtered pad brownout condition asserts `brownout_rst` in the cycle after it is seen.
- R8: A filtered core brownout condition asserts `brownout_rst` in the same way as a pad brownout.
- R9: `brownout_rst` is released 16 cycles after the last brownout condition has cleared in the filter. If a brownout condition returns during that hold, the hold restarts from zero.
- R10: After `rst_n` is released, `brownout_rst` stays high for 17 cycles and then goes low. While `rst_n` is low, both clock enables are 1 and `core_ok` is 0.

Blanking FSM: BL_RUN → BL_FREEZE on a drop rise. BL_FREEZE → BL_SETTLE when the count ends while the drop condition is still high. BL_FREEZE → BL_RUN when the count ends with the drop condition low. BL_SETTLE → BL_RUN when the drop condition clears.

Reset FSM: RS_ASSERT → RS_HOLD when no brownout condition is present. RS_HOLD → RS_ASSERT when a brownout condition returns. RS_HOLD → RS_RELEASE when the hold count completes. RS_RELEASE → RS_ASSERT on any brownout condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, free running |
| rst_n | input | 1 | Asynchronous active-low reset of the monitor |
| pad_warn_raw | input | 1 | Comparator: pad supply below pre-warning level |
| pad_bo_raw | input | 1 | Comparator: pad supply below brownout level |
| core_clip_raw | input | 1 | Comparator: core supply above clip level |
| core_drop_raw | input | 1 | Comparator: core supply below drop level |
| core_bo_raw | input | 1 | Comparator: core supply below brownout level |
| blank_len | input | 8 | Freeze length in reference cycles (0 selects 8) |
| pad_warn_irq | output | 1 | One-cycle pre-warning interrupt |
| core_clip_irq | output | 1 | One-cycle clip warning interrupt |
| core_drop_irq | output | 1 | One-cycle drop warning interrupt |
| brownout_rst | output | 1 | Reset request, high while held |
| mclk_en | output | 1 | Main clock enable, changes on the falling edge |
| pclk_en | output | 1 | Peripheral clock enable, changes on the falling edge |
| core_ok | output | 1 | Core supply stable status |

## Verification
The bench sends a 2-cycle glitch. A filter that is too short or missing would answer it with a spurious interrupt. It runs blanking with lengths 3 and 5 and with the zero value. An off-by-one counter would show one cycle too many or too few, and a zero that is not remapped would freeze for one cycle or wrap to 255. With the drop condition held past the freeze, `core_ok` must stay low even though the clocks run again; a design that ties status to the freeze alone would raise it early. A brownout that returns during the release hold must restart the hold. A design that only pauses the count, or never restarts it, would drop the reset request too early.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;

    localparam int NUM_CH     = 5;
    localparam int CH_PAD_WRN = 0;
    localparam int CH_PAD_BO  = 1;
    localparam int CH_CLIP    = 2;
    localparam int CH_DROP    = 3;
    localparam int CH_CORE_BO = 4;

    typedef enum logic [1:0] {
        BL_RUN    = 2'd0,
        BL_FREEZE = 2'd1,
        BL_SETTLE = 2'd2
    } blank_state_t;

    typedef enum logic [1:0] {
        RS_ASSERT  = 2'd0,
        RS_HOLD    = 2'd1,
        RS_RELEASE = 2'd2
    } rst_state_t;

endpackage

// File: rtl/sg_sync_filter.sv
module sg_sync_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic flag,
    output logic rise
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          run_cnt;
    logic                   flag_q;
    logic                   flag_d;
    logic                   differs;

    assign differs = sync_q[SYNC_STAGES-1] != flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
            flag_q  <= 1'b0;
            flag_d  <= 1'b0;
        end else begin
            flag_d <= flag_q;
            if (!differs) begin
                run_cnt <= '0;
            end else if (run_cnt == CW'(FILT_LEN - 1)) begin
                run_cnt <= '0;
                flag_q  <= sync_q[SYNC_STAGES-1];
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    assign flag = flag_q;
    assign rise = flag_q & ~flag_d;

endmodule

// File: rtl/sg_blank_fsm.sv
module sg_blank_fsm
    import supply_guard_pkg::*;
#(
    parameter int LEN_W     = 8,
    parameter int BLANK_DEF = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             drop_rise,
    input  logic             drop_flag,
    input  logic             core_bo_flag,
    input  logic [LEN_W-1:0] blank_len,
    output logic             mclk_en,
    output logic             pclk_en,
    output logic             core_ok
);
    blank_state_t     state_q, state_n;
    logic [LEN_W-1:0] cnt_q, cnt_n;
    logic [LEN_W-1:0] load_len;
    logic             run_n;
    logic             mclk_en_q, pclk_en_q;

    assign load_len = (blank_len == '0) ? LEN_W'(BLANK_DEF) : blank_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BL_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        run_n   = 1'b1;
        unique case (state_q)
            BL_RUN: begin
                if (drop_rise) begin
                    state_n = BL_FREEZE;
                    cnt_n   = load_len;
                end
            end
            BL_FREEZE: begin
                run_n = 1'b0;
                if (cnt_q <= LEN_W'(1)) begin
                    state_n = drop_flag ? BL_SETTLE : BL_RUN;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            BL_SETTLE: begin
                if (!drop_flag) begin
                    state_n = BL_RUN;
                end
            end
            default: begin
                state_n = BL_RUN;
            end
        endcase
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mclk_en_q <= 1'b1;
            pclk_en_q <= 1'b1;
        end else begin
            mclk_en_q <= run_n;
            pclk_en_q <= run_n;
        end
    end

    assign mclk_en = mclk_en_q;
    assign pclk_en = pclk_en_q;
    assign core_ok = rst_n & (state_q == BL_RUN) & ~core_bo_flag;

endmodule

// File: rtl/sg_reset_fsm.sv
module sg_reset_fsm
    import supply_guard_pkg::*;
#(
    parameter int HOLD_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bo_any,
    output logic rst_req
);
    localparam int HW = $clog2(HOLD_CYC + 1);

    rst_state_t    state_q, state_n;
    logic [HW-1:0] hold_q, hold_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_ASSERT;
            hold_q  <= '0;
        end else begin
            state_q <= state_n;
            hold_q  <= hold_n;
        end
    end

    always_comb begin
        state_n = state_q;
        hold_n  = hold_q;
        unique case (state_q)
            RS_ASSERT: begin
                hold_n = '0;
                if (!bo_any) begin
                    state_n = RS_HOLD;
                end
            end
            RS_HOLD: begin
                if (bo_any) begin
                    state_n = RS_ASSERT;
                    hold_n  = '0;
                end else if (hold_q == HW'(HOLD_CYC - 1)) begin
                    state_n = RS_RELEASE;
                    hold_n  = '0;
                end else begin
                    hold_n = hold_q + 1'b1;
                end
            end
            RS_RELEASE: begin
                if (bo_any) begin
                    state_n = RS_ASSERT;
                end
            end
            default: begin
                state_n = RS_ASSERT;
            end
        endcase
    end

    assign rst_req = (state_q != RS_RELEASE);

endmodule

// File: rtl/supply_guard.sv
module supply_guard
    import supply_guard_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4,
    parameter int LEN_W       = 8,
    parameter int BLANK_DEF   = 8,
    parameter int HOLD_CYC    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pad_warn_raw,
    input  logic             pad_bo_raw,
    input  logic             core_clip_raw,
    input  logic             core_drop_raw,
    input  logic             core_bo_raw,
    input  logic [LEN_W-1:0] blank_len,
    output logic             pad_warn_irq,
    output logic             core_clip_irq,
    output logic             core_drop_irq,
    output logic             brownout_rst,
    output logic             mclk_en,
    output logic             pclk_en,
    output logic             core_ok
);
    logic [NUM_CH-1:0] raw_vec;
    logic [NUM_CH-1:0] flt;
    logic [NUM_CH-1:0] flt_rise;
    logic [2:0]        irq_q;
    logic              bo_any;

    assign raw_vec[CH_PAD_WRN] = pad_warn_raw;
    assign raw_vec[CH_PAD_BO]  = pad_bo_raw;
    assign raw_vec[CH_CLIP]    = core_clip_raw;
    assign raw_vec[CH_DROP]    = core_drop_raw;
    assign raw_vec[CH_CORE_BO] = core_bo_raw;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        sg_sync_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_vec[ch]),
            .flag (flt[ch]),
            .rise (flt_rise[ch])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else begin
            irq_q <= {flt_rise[CH_DROP], flt_rise[CH_CLIP], flt_rise[CH_PAD_WRN]};
        end
    end

    assign pad_warn_irq  = irq_q[0];
    assign core_clip_irq = irq_q[1];
    assign core_drop_irq = irq_q[2];

    assign bo_any = flt[CH_PAD_BO] | flt[CH_CORE_BO];

    sg_blank_fsm #(
        .LEN_W    (LEN_W),
        .BLANK_DEF(BLANK_DEF)
    ) u_blank (
        .clk         (clk),
        .rst_n       (rst_n),
        .drop_rise   (flt_rise[CH_DROP]),
        .drop_flag   (flt[CH_DROP]),
        .core_bo_flag(flt[CH_CORE_BO]),
        .blank_len   (blank_len),
        .mclk_en     (mclk_en),
        .pclk_en     (pclk_en),
        .core_ok     (core_ok)
    );

    sg_reset_fsm #(
        .HOLD_CYC(HOLD_CYC)
    ) u_rst (
        .clk    (clk),
        .rst_n  (rst_n),
        .bo_any (bo_any),
        .rst_req(brownout_rst)
    );

endmodule

// File: rtl/supply_guard_chk.sv
module supply_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic pad_warn_irq,
    input logic core_clip_irq,
    input logic mclk_en,
    input logic pclk_en,
    input logic core_ok,
    input logic brownout_rst,
    input logic bo_any
);
    // R2: pre-warning interrupt is a single-cycle pulse
    p_pulse_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pad_warn_irq |=> !pad_warn_irq);

    // R3: clip interrupt is a single-cycle pulse
    p_pulse_clip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        core_clip_irq |=> !core_clip_irq);

    // R5: both clock enables move together
    p_clk_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mclk_en == pclk_en);

    // R6: status is low whenever the clocks are frozen
    p_frozen_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mclk_en |-> !core_ok);

    // R7, R8: a filtered brownout forces the reset request next cycle
    p_bo_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bo_any |=> brownout_rst);
endmodule

bind supply_guard supply_guard_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pad_warn_irq (pad_warn_irq),
    .core_clip_irq(core_clip_irq),
    .mclk_en      (mclk_en),
    .pclk_en      (pclk_en),
    .core_ok      (core_ok),
    .brownout_rst (brownout_rst),
    .bo_any       (bo_any)
);

// File: tb/sim_supply_guard.sv
`timescale 1ns/1ps
module sim_supply_guard;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pad_warn_raw = 1'b0, pad_bo_raw = 1'b0, core_clip_raw = 1'b0;
    logic       core_drop_raw = 1'b0, core_bo_raw = 1'b0;
    logic [7:0] blank_len = 8'd0;
    logic       pad_warn_irq, core_clip_irq, core_drop_irq;
    logic       brownout_rst, mclk_en, pclk_en, core_ok;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    supply_guard u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .pad_warn_raw (pad_warn_raw),
        .pad_bo_raw   (pad_bo_raw),
        .core_clip_raw(core_clip_raw),
        .core_drop_raw(core_drop_raw),
        .core_bo_raw  (core_bo_raw),
        .blank_len    (blank_len),
        .pad_warn_irq (pad_warn_irq),
        .core_clip_irq(core_clip_irq),
        .core_drop_irq(core_drop_irq),
        .brownout_rst (brownout_rst),
        .mclk_en      (mclk_en),
        .pclk_en      (pclk_en),
        .core_ok      (core_ok)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // step to one ns after the next rising edge
    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic t_power_on();
        rst_n = 1'b0;
        tick(2);
        check("R10 en during reset", int'(mclk_en & pclk_en), 1);
        check("R10 core_ok during reset", int'(core_ok), 0);
        @(negedge clk);
        rst_n = 1'b1;
        tick(15);
        check("R10 held after 15", int'(brownout_rst), 1);
        tick(5);
        check("R10 released", int'(brownout_rst), 0);
        check("R10 core_ok after release", int'(core_ok), 1);
    endtask

    task automatic t_glitch();
        int hits = 0;
        @(negedge clk);
        pad_warn_raw = 1'b1;
        pad_bo_raw   = 1'b1;
        @(negedge clk);
        @(negedge clk);
        pad_warn_raw = 1'b0;
        pad_bo_raw   = 1'b0;
        for (int i = 0; i < 20; i++) begin
            tick(1);
            hits += int'(pad_warn_irq) + int'(brownout_rst);
        end
        check("R1 glitch ignored", hits, 0);
    endtask

    task automatic t_irq(input int which);
        int pulses = 0;
        @(negedge clk);
        if (which == 0) pad_warn_raw = 1'b1;
        else            core_clip_raw = 1'b1;
        for (int i = 0; i < 30; i++) begin
            tick(1);
            pulses += (which == 0) ? int'(pad_warn_irq) : int'(core_clip_irq);
        end
        if (which == 0) check("R2 one pre-warning pulse", pulses, 1);
        else            check("R3 one clip pulse", pulses, 1);
        @(negedge clk);
        pad_warn_raw  = 1'b0;
        core_clip_raw = 1'b0;
        tick(12);
    endtask

    task automatic t_drop(input int len, input int exp_len);
        int low = 0, pulses = 0, mism = 0, okbad = 0;
        blank_len = 8'(len);
        @(negedge clk);
        core_drop_raw = 1'b1;
        for (int i = 0; i < 30; i++) begin
            tick(1);
            low    += int'(!mclk_en);
            pulses += int'(core_drop_irq);
            mism   += int'(mclk_en != pclk_en);
            okbad  += int'(!mclk_en && core_ok);
        end
        check("R5 freeze length", low, exp_len);
        check("R5 enables equal", mism, 0);
        check("R4 one drop pulse", pulses, 1);
        check("R6 ok low while frozen", okbad, 0);
        check("R6 ok low while drop held", int'(core_ok), 0);
        check("R5 clocks run after freeze", int'(mclk_en), 1);
        @(negedge clk);
        core_drop_raw = 1'b0;
        tick(10);
        check("R6 ok after recovery", int'(core_ok), 1);
    endtask

    task automatic t_brownout(input int which);
        int first_low = -1;
        @(negedge clk);
        if (which == 0) pad_bo_raw = 1'b1;
        else            core_bo_raw = 1'b1;
        tick(10);
        if (which == 0) check("R7 pad brownout reset", int'(brownout_rst), 1);
        else begin
            check("R8 core brownout reset", int'(brownout_rst), 1);
            check("R6 ok low in core brownout", int'(core_ok), 0);
        end
        @(negedge clk);
        pad_bo_raw  = 1'b0;
        core_bo_raw = 1'b0;
        for (int i = 1; i <= 40; i++) begin
            tick(1);
            if (first_low < 0 && !brownout_rst) first_low = i;
        end
        // filter clears about 6 cycles in, then 16 cycles of hold
        check("R9 release delay", first_low, 23);
    endtask

    task automatic t_hold_restart();
        @(negedge clk);
        pad_bo_raw = 1'b1;
        tick(10);
        @(negedge clk);
        pad_bo_raw = 1'b0;
        tick(12);
        @(negedge clk);
        core_bo_raw = 1'b1;
        tick(8);
        @(negedge clk);
        core_bo_raw = 1'b0;
        tick(10);
        check("R9 hold restarted", int'(brownout_rst), 1);
        tick(30);
        check("R9 released after restart", int'(brownout_rst), 0);
    endtask

    initial begin
        t_power_on();
        t_glitch();
        t_irq(0);
        t_irq(1);
        t_drop(3, 3);
        t_drop(5, 5);
        t_drop(0, 8);
        t_brownout(0);
        t_brownout(1);
        t_hold_restart();
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule